// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Register Slave

This block is a slave on a two-wire serial bus. It gives a bus master access to a small register bank through a pointer register. The block runs on a system clock and oversamples the bus clock (SCL) and data (SDA) lines through synchronizers. It finds start and stop conditions on the synchronized lines and decodes addressed transfers. It drives SDA only by pulling it low, through a single enable output that the pad logic turns into an open-drain driver.

The 7-bit bus address comes from two three-level strap inputs. These are read once, one cycle after reset is released. The block then ignores them until the next reset. The master uses three kinds of transfer:
- writing only the pointer;
- writing the pointer and then data to the register the pointer selects;
- reading from the register the pointer already holds.

The pointer keeps its value from one transaction to the next. It never advances by itself.

Top module: `twi_strap_slave`

## Requirements
- R1: Each strap input is a 2-bit code: 00 low, 01 high, 10 or 11 unconnected. The level values are low=0, high=1 and unconnected=2. The index is 3*level(strap_a)+level(strap_b). Index 0 to 8 selects, in that order, the addresses 0101001, 0101010, 1001100, 1001101, 0011000, 0011001, 0011010, 0101011, 1001110. The address is captured one cycle after reset is released, and later strap changes have no effect.
- R2: After a start (SDA falls while SCL is high), the first 8 bits are taken MSB first as the address and then R/W (0 = master writes, 1 = master reads). On a match, SDA is pulled low before the ninth SCL rise and held through that ninth clock pulse.
- R3: A byte whose 7-bit address does not match gets no acknowledge. SDA stays released until the next start.
- R4: In a write, the first data byte loads the pointer. A write that stops after that byte leaves every register unchanged.
- R5: Every data byte in an addressed write is acknowledged. The second and later data bytes are each written to the register the pointer selects, so the last one written remains.
- R6: A read returns the register the pointer selects, MSB first, using the pointer left by an earlier transaction.
- R7: While the master acknowledges, a read goes on returning the same register, because the pointer does not increment. After a not-acknowledge, SDA stays released.
- R8: Pointer values at or above NUM_REGS (4) are accepted and acknowledged. Writes to them are discarded, and reads from them return 0xFF.
- R9: A start inside a transfer, at any bit position, restarts address reception.
- R10: A stop (SDA rises while SCL is high) returns the block to idle with SDA released. The pull output changes only while SCL is low.
- R11: After reset the pointer is 0, every register holds 0x00, and SDA is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_a | input | 2 | First address strap level code |
| strap_b | input | 2 | Second address strap level code |
| sda_pull_o | output | 1 | High to pull SDA low |

## Verification
Two actions fall on the same SCL falling edge. That edge ends the address acknowledge, and the same edge also puts the first read bit on the line. If the MSB of that bit is 0, the pull must stay asserted with no gap. If the MSB is 1, the pull must drop. The bench provokes this by reading register values whose MSB is 0 and values whose MSB is 1, such as 0x11 and 0xFF. It judges the result by sampling SDA late in each SCL high phase. A second coincidence is a repeated start that arrives while a byte is half shifted. The bench sends four stray bits, starts again, and requires that the next address is acknowledged.

// File: rtl/twi_pkg.sv
// Package: shared types and constants for the strap-addressed two-wire slave.
// Assumes a byte-wide protocol with a 7-bit address.
package twi_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_WR,
        ST_RD,
        ST_RDACK
    } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
// twi_line_sync: brings SCL and SDA into the clk domain through STAGES flops
// and flags SCL edges plus start/stop conditions on the synchronized lines.
// Assumes the bus is idle high during reset and STAGES >= 2.
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Shift both lines through the synchronizer and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twi_strap_decode.sv
// twi_strap_decode: turns two three-level strap codes into a 7-bit device
// address, captured once in the first cycle after reset is released.
// Assumes code 11 means the same as unconnected.
module twi_strap_decode (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_a,
    input  logic [1:0] strap_b,
    output logic [6:0] dev_addr,
    output logic       addr_valid
);
    logic [3:0] sel;
    logic [6:0] addr_lut;

    function automatic logic [3:0] level(input logic [1:0] code);
        return code[1] ? 4'd2 : {3'd0, code[0]};
    endfunction

    // Combine the two strap levels into an index and look up the address.
    always_comb begin
        sel = 4'(level(strap_a) * 4'd3 + level(strap_b));
        case (sel)
            4'd0:    addr_lut = 7'b0101001;
            4'd1:    addr_lut = 7'b0101010;
            4'd2:    addr_lut = 7'b1001100;
            4'd3:    addr_lut = 7'b1001101;
            4'd4:    addr_lut = 7'b0011000;
            4'd5:    addr_lut = 7'b0011001;
            4'd6:    addr_lut = 7'b0011010;
            4'd7:    addr_lut = 7'b0101011;
            default: addr_lut = 7'b1001110;
        endcase
    end

    // Capture the address once after reset and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_addr   <= '0;
            addr_valid <= 1'b0;
        end else if (!addr_valid) begin
            dev_addr   <= addr_lut;
            addr_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/twi_reg_bank.sv
// twi_reg_bank: NUM_REGS byte registers addressed by a byte-wide index.
// Indices at or above NUM_REGS ignore writes and read back all ones.
module twi_reg_bank #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int IDX_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // Each register loads when the write index selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                regs[g] <= wr_data;
            end
        end
    end

    // Read mux with an all-ones default for indices that have no register.
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = regs[i];
        end
    end
endmodule

// File: rtl/twi_strap_slave.sv
// twi_strap_slave: two-wire slave with a strap-selected address, a pointer
// register that persists between transactions, and a small register bank.
// Assumes SDA changes only while SCL is low, except at start and stop, and
// that clk oversamples SCL by a wide margin. No clock stretching.
module twi_strap_slave #(
    parameter int NUM_REGS    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_a,
    input  logic [1:0] strap_b,
    output logic       sda_pull_o
);
    import twi_pkg::*;

    localparam logic [CNT_W-1:0] BITS_DONE = CNT_W'(BYTE_W);

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [ADDR_W-1:0] dev_addr;
    logic              addr_valid;
    twi_state_e        state;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txreg;
    logic [BYTE_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;
    logic              ptr_done;
    logic              rw;
    logic              master_ack;
    logic              reg_wr;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twi_strap_decode u_strap (
        .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
        .dev_addr(dev_addr), .addr_valid(addr_valid)
    );

    // Data bytes after the pointer byte go to the selected register.
    assign reg_wr = (state == ST_WR) && scl_fall && (bit_cnt == BITS_DONE) && ptr_done;

    twi_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(BYTE_W), .IDX_W(BYTE_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(ptr),
        .wr_data(shreg), .rd_idx(ptr), .rd_data(rd_data)
    );

    // Protocol sequencer: address match, acknowledge, write and read phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            shreg      <= '0;
            txreg      <= '0;
            ptr        <= '0;
            ptr_done   <= 1'b0;
            rw         <= 1'b0;
            master_ack <= 1'b0;
            sda_pull_o <= 1'b0;
        end else if (start_evt) begin
            state      <= ST_ADDR;
            bit_cnt    <= '0;
            sda_pull_o <= 1'b0;
        end else if (stop_evt) begin
            state      <= ST_IDLE;
            sda_pull_o <= 1'b0;
        end else begin
            case (state)
                ST_ADDR: begin
                    if (scl_rise && bit_cnt < BITS_DONE) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (scl_fall && bit_cnt == BITS_DONE) begin
                        if (addr_valid && shreg[BYTE_W-1:1] == dev_addr) begin
                            rw         <= shreg[0];
                            ptr_done   <= 1'b0;
                            sda_pull_o <= 1'b1;
                            state      <= ST_ACK;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw) begin
                            txreg      <= rd_data;
                            sda_pull_o <= ~rd_data[BYTE_W-1];
                            state      <= ST_RD;
                        end else begin
                            sda_pull_o <= 1'b0;
                            state      <= ST_WR;
                        end
                    end
                end
                ST_WR: begin
                    if (scl_rise && bit_cnt < BITS_DONE) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (scl_fall && bit_cnt == BITS_DONE) begin
                        if (!ptr_done) begin
                            ptr      <= shreg;
                            ptr_done <= 1'b1;
                        end
                        sda_pull_o <= 1'b1;
                        state      <= ST_ACK;
                    end
                end
                ST_RD: begin
                    if (scl_rise && bit_cnt < BITS_DONE) begin
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end else if (scl_fall) begin
                        if (bit_cnt == BITS_DONE) begin
                            sda_pull_o <= 1'b0;
                            state      <= ST_RDACK;
                        end else begin
                            txreg      <= {txreg[BYTE_W-2:0], 1'b0};
                            sda_pull_o <= ~txreg[BYTE_W-2];
                        end
                    end
                end
                ST_RDACK: begin
                    if (scl_rise) begin
                        master_ack <= ~sda_s;
                    end else if (scl_fall) begin
                        if (master_ack) begin
                            bit_cnt    <= '0;
                            txreg      <= rd_data;
                            sda_pull_o <= ~rd_data[BYTE_W-1];
                            state      <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: sda_pull_o <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/twi_slave_checker.sv
// twi_slave_checker: protocol properties for twi_strap_slave, bound in below.
module twi_slave_checker (
    input logic                clk,
    input logic                rst_n,
    input twi_pkg::twi_state_e state,
    input logic                sda_pull,
    input logic                scl_s,
    input logic                stop_evt,
    input logic [6:0]          dev_addr,
    input logic                addr_valid,
    input logic [3:0]          bit_cnt
);
    import twi_pkg::*;

    assert_addr_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && $past(addr_valid)) |-> $stable(dev_addr));

    assert_ack_pulls_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK) |-> sda_pull);

    assert_bitcnt_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= 4'd8);

    assert_quiet_when_listening_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_ADDR || state == ST_WR) |-> !sda_pull);

    assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (!sda_pull && state == ST_IDLE));

    assert_pull_steady_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_pull));
endmodule

bind twi_strap_slave twi_slave_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .sda_pull(sda_pull_o),
    .scl_s(scl_s), .stop_evt(stop_evt), .dev_addr(dev_addr),
    .addr_valid(addr_valid), .bit_cnt(bit_cnt)
);

// File: tb/tb_twi_strap_slave.sv
module tb_twi_strap_slave;
    localparam int NREG = 4;
    localparam int Q    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap_a = 2'b00;
    logic [1:0] strap_b = 2'b00;
    logic       sda_pull_o;
    wire        sda_bus = m_sda & ~sda_pull_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [6:0] cur_addr;

    always #2.5 clk = ~clk;

    twi_strap_slave #(.NUM_REGS(NREG), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .strap_a(strap_a), .strap_b(strap_b), .sda_pull_o(sda_pull_o)
    );

    function automatic logic [6:0] exp_addr(input int idx);
        case (idx)
            0: return 7'b0101001;
            1: return 7'b0101010;
            2: return 7'b1001100;
            3: return 7'b1001101;
            4: return 7'b0011000;
            5: return 7'b0011001;
            6: return 7'b0011010;
            7: return 7'b0101011;
            default: return 7'b1001110;
        endcase
    endfunction

    function automatic logic [7:0] pat(input int p);
        return 8'((p * 53 + 17) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] a, input logic [1:0] b);
        @(negedge clk);
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1;
        strap_a = a; strap_b = b;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit pre;
        send_bits(b, 8);
        m_sda = 1'b1; wq();
        pre = !sda_bus;
        m_scl = 1'b1; wq();
        ack = pre && !sda_bus;
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b[i] = sda_bus; m_scl = 1'b0; wq();
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wq(); m_scl = 1'b1; wq(); m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    // Write pointer, optionally followed by data bytes; reports all acks.
    task automatic wr_txn(input logic [7:0] p, input int nd, input logic [7:0] d0,
                          input logic [7:0] d1, input string req);
        bit ack;
        bus_start();
        send_byte({cur_addr, 1'b0}, ack); chk(ack, req, ack, 1);
        send_byte(p, ack);                chk(ack, req, ack, 1);
        if (nd > 0) begin send_byte(d0, ack); chk(ack, req, ack, 1); end
        if (nd > 1) begin send_byte(d1, ack); chk(ack, req, ack, 1); end
        bus_stop();
    endtask

    task automatic rd_check(input int n, input logic [7:0] exp, input string req);
        bit ack;
        logic [7:0] v;
        bus_start();
        send_byte({cur_addr, 1'b1}, ack); chk(ack, req, ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(k != n - 1, v);
            chk(v == exp, req, v, exp);
        end
        bus_stop();
        chk(sda_pull_o == 1'b0, "R10 released after stop", sda_pull_o, 0);
    endtask

    initial begin
        bit ack;
        logic [7:0] v;
        // R11: reset state.
        do_reset(2'b00, 2'b00);
        cur_addr = exp_addr(0);
        chk(sda_pull_o == 1'b0, "R11 pull idle", sda_pull_o, 0);
        rd_check(1, 8'h00, "R11 reg0 after reset");

        // R1, R2, R3: sweep all strap combinations.
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                do_reset(2'(a), 2'(b));
                cur_addr = exp_addr(a * 3 + b);
                bus_start();
                send_byte({cur_addr, 1'b0}, ack);
                chk(ack, "R1 R2 strap address ack", ack, 1);
                send_byte(8'h01, ack);
                bus_stop();
                bus_start();
                send_byte({exp_addr((a * 3 + b + 1) % 9), 1'b0}, ack);
                chk(!ack, "R3 wrong address nack", ack, 0);
                send_byte(8'h00, ack);
                chk(!ack, "R3 stays quiet", ack, 0);
                bus_stop();
            end
        end
        // R1: code 11 acts as unconnected.
        do_reset(2'b11, 2'b11);
        cur_addr = exp_addr(8);
        bus_start(); send_byte({cur_addr, 1'b1}, ack); chk(ack, "R1 code 11", ack, 1);
        recv_byte(1'b0, v); bus_stop();
        // R1: strap change after capture is ignored.
        do_reset(2'b00, 2'b00);
        cur_addr = exp_addr(0);
        strap_a = 2'b01; strap_b = 2'b10;
        repeat (4) @(negedge clk);
        bus_start(); send_byte({exp_addr(5), 1'b0}, ack);
        chk(!ack, "R1 late strap ignored", ack, 0); bus_stop();
        bus_start(); send_byte({cur_addr, 1'b0}, ack);
        chk(ack, "R1 latched address kept", ack, 1); bus_stop();

        // R5, R8: write a pattern to in-range and out-of-range pointers.
        for (int p = 0; p < NREG + 2; p++) wr_txn(8'(p), 1, pat(p), 8'h00, "R5 R8 write acks");
        // R4, R6, R7, R8: pointer-only write then multi-byte read.
        for (int p = 0; p < NREG + 2; p++) begin
            wr_txn(8'(p), 0, 8'h00, 8'h00, "R4 pointer write");
            rd_check(3, (p < NREG) ? pat(p) : 8'hFF, "R6 R7 R8 read back");
        end
        // R4: a pointer-only write leaves register contents unchanged.
        wr_txn(8'd1, 0, 8'h00, 8'h00, "R4 pointer only");
        wr_txn(8'd2, 0, 8'h00, 8'h00, "R4 pointer only");
        rd_check(1, pat(2), "R4 R6 persistent pointer");
        wr_txn(8'd1, 0, 8'h00, 8'h00, "R4 pointer only");
        rd_check(1, pat(1), "R4 reg unchanged");
        // R5: two data bytes hit the same register; the neighbour is untouched.
        wr_txn(8'd1, 2, 8'h3C, 8'h11, "R5 two data bytes");
        rd_check(2, 8'h11, "R5 last data kept");
        wr_txn(8'd2, 0, 8'h00, 8'h00, "R5 pointer");
        rd_check(1, pat(2), "R5 no auto increment");
        // R9: repeated start after a pointer write, then read.
        wr_txn(8'd3, 1, 8'hFF, 8'h00, "R9 setup");
        bus_start();
        send_byte({cur_addr, 1'b0}, ack); send_byte(8'd1, ack);
        bus_start();
        send_byte({cur_addr, 1'b1}, ack); chk(ack, "R9 repeated start ack", ack, 1);
        recv_byte(1'b0, v); chk(v == 8'h11, "R9 read after restart", v, 8'h11);
        bus_stop();
        // R9: restart in the middle of a byte.
        bus_start();
        send_bits(8'hA5, 4);
        bus_start();
        send_byte({cur_addr, 1'b1}, ack); chk(ack, "R9 mid-byte restart", ack, 1);
        recv_byte(1'b0, v); chk(v == 8'h11, "R9 mid-byte read", v, 8'h11);
        bus_stop();
        rd_check(1, 8'h11, "R10 idle after stop");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule